// File: doc/BRIEF.md
# Rewindable FIFO with Half-Full Status

This block is a single-clock first-in/first-out buffer for 9-bit words. The ninth bit is free for parity or a control marker. The depth is a power-of-two parameter. A producer presents a word together with a one-cycle write strobe. A consumer raises a one-cycle read strobe and receives the oldest stored word on a registered output in the following cycle, along with a one-cycle valid pulse. Three active-low status outputs report the buffer's fill state: empty, more-than-half full, and full. The block uses these conditions to refuse strobes that would overflow or underflow it.

A rewind control moves the read side back to the first location written since reset and leaves the write side untouched. All words written since reset can then be replayed. After a rewind the three status outputs are recomputed from the new distance between the two pointers. A rewind is honoured only in a cycle with both strobes idle. Reset is asynchronous on assertion and is released to the logic two clock edges after the reset input rises.

Top module: `fifo_rt`

## Requirements
- R1: Words are 9 bits wide, and all 9 bits, bit 8 included, come out in the order they were written.
- R2: While reset is held and after its release, empty_n is 0, full_n is 1, half_n is 1 and rd_valid is 0. Both pointers sit at location 0.
- R3: full_n falls in the cycle after the write that occupies the last free location. A write strobe while full_n is 0 is ignored: it stores nothing and moves no pointer.
- R4: full_n returns to 1 in the cycle after a read is accepted from a full buffer.
- R5: empty_n falls in the cycle after the read that removes the last word, and that read still returns its word. A read strobe while empty_n is 0 is ignored: rd_valid stays 0 and the read pointer does not move.
- R6: empty_n returns to 1 in the cycle after a write is accepted into an empty buffer, and a read may follow at once.
- R7: half_n is 0 exactly when the occupancy is greater than DEPTH/2. It falls on the write that crosses that level and rises on the read that brings the occupancy back to DEPTH/2 or below.
- R8: An accepted rewind sets the read pointer to location 0 and keeps the write pointer. The next cycle's flags then reflect an occupancy equal to the number of words written since reset (defined while that number is at most DEPTH).
- R9: A rewind request in a cycle where the write strobe or the read strobe is high is ignored, and the strobes take effect as usual.
- R10: When the buffer is neither empty nor full, a write and a read in the same cycle are both performed, and the occupancy and all three flags stay the same.
- R11: Read data is registered. rd_valid is 1 for exactly the one cycle after each accepted read and 0 in every other cycle, and rd_data carries the word during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_stb | input | 1 | Write request for this cycle |
| wr_data | input | 9 | Word to be stored |
| rd_stb | input | 1 | Read request for this cycle |
| rewind | input | 1 | Request to move the read side back to location 0 |
| rd_data | output | 9 | Registered word from the last accepted read |
| rd_valid | output | 1 | High one cycle after an accepted read |
| empty_n | output | 1 | Low when no word is stored |
| half_n | output | 1 | Low when more than half of the locations are in use |
| full_n | output | 1 | Low when every location is in use |

## Verification
The bench builds the block with DEPTH set to 8. At that depth the full point and the half-full threshold of 4 words are only a few strobes away, so every flag transition can be driven directly and its exact cycle checked. A depth of 8 also lets a single run write eight words since reset and then rewind. That brings the rewind-to-full case, where the replay occupancy equals the whole depth, within reach, along with the ignored strobes at both ends and rewind requests that collide with strobes.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  parameter int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fifo_rt_ptrs.sv
// Pointer control: accepts or refuses strobes and the rewind request,
// and produces the occupancy that the flag stage registers.
module fifo_rt_ptrs #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          rewind,
  input  logic          full_n,
  input  logic          empty_n,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [LW-1:0] level_nxt
);
  logic [LW-1:0] wr_ptr_q, wr_ptr_d;
  logic [LW-1:0] rd_ptr_q, rd_ptr_d;
  logic          rewind_go;

  always_comb begin
    wr_go     = wr_stb & full_n;
    rd_go     = rd_stb & empty_n;
    rewind_go = rewind & ~wr_stb & ~rd_stb;

    wr_ptr_d = wr_ptr_q;
    if (wr_go) wr_ptr_d = wr_ptr_q + LW'(1);

    rd_ptr_d = rd_ptr_q;
    if (rewind_go)  rd_ptr_d = '0;
    else if (rd_go) rd_ptr_d = rd_ptr_q + LW'(1);

    level_nxt = wr_ptr_d - rd_ptr_d;
    wr_addr   = wr_ptr_q[AW-1:0];
    rd_addr   = rd_ptr_q[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_go) wr_ptr_q <= wr_ptr_d;
      if (rewind_go || rd_go) rd_ptr_q <= rd_ptr_d;
    end
  end
endmodule

// File: rtl/fifo_rt_flags.sv
// Status flags registered from the next-cycle occupancy.
module fifo_rt_flags #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level_nxt,
  output logic          empty_n,
  output logic          half_n,
  output logic          full_n
);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);
  localparam logic [LW-1:0] LVL_HALF = LW'(DEPTH / 2);

  logic empty_n_d, half_n_d, full_n_d;

  always_comb begin
    empty_n_d = (level_nxt != '0);
    full_n_d  = (level_nxt != LVL_FULL);
    half_n_d  = (level_nxt <= LVL_HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_n <= 1'b0;
      half_n  <= 1'b1;
      full_n  <= 1'b1;
    end else begin
      empty_n <= empty_n_d;
      half_n  <= half_n_d;
      full_n  <= full_n_d;
    end
  end
endmodule

// File: rtl/fifo_rt_store.sv
// Word storage with a registered read port and a valid pulse.
module fifo_rt_store
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wr_word,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_word,
  output logic          rd_valid
);
  word_t mem [DEPTH];
  word_t rd_word_d;

  always_comb rd_word_d = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_word <= rd_word_d;
    end
  end
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              rewind,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty_n,
  output logic              half_n,
  output logic              full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [1:0]    rst_pipe;
  logic          rst_q;
  logic          wr_go, rd_go;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [LW-1:0] level_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  fifo_rt_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_q), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .rewind(rewind), .full_n(full_n), .empty_n(empty_n),
    .wr_go(wr_go), .rd_go(rd_go), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .level_nxt(level_nxt)
  );

  fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_q), .level_nxt(level_nxt),
    .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
  );

  fifo_rt_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_q), .wr_go(wr_go), .wr_addr(wr_addr),
    .wr_word(wr_data), .rd_go(rd_go), .rd_addr(rd_addr),
    .rd_word(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic rd_stb,
  input logic rd_valid,
  input logic empty_n,
  input logic half_n,
  input logic full_n
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_stb && !rd_stb) |=> !full_n);

  // R4
  full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && rd_stb) |=> full_n);

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_stb) |=> !rd_valid);

  // R6
  empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && wr_stb) |=> empty_n);

  // R7
  half_vs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_n);

  // R7
  half_vs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> half_n);

  // R10
  steady_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n && full_n && wr_stb && rd_stb) |=> $stable({empty_n, half_n, full_n}));

  // R11
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && empty_n) |=> rd_valid);

  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);
endmodule

bind fifo_rt fifo_rt_chk u_chk (
  .clk(clk), .rst_n(rst_q), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .rd_valid(rd_valid), .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
);

// File: tb/fifo_rt_bench.sv
module fifo_rt_bench;
  localparam int DEPTH = 8;

  logic       clk;
  logic       rst_n;
  logic       wr_stb;
  logic [8:0] wr_data;
  logic       rd_stb;
  logic       rewind;
  logic [8:0] rd_data;
  logic       rd_valid;
  logic       empty_n;
  logic       half_n;
  logic       full_n;

  int n_checks;
  int n_fails;
  bit done;

  fifo_rt #(.DEPTH(DEPTH)) u_fifo_rt (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rewind(rewind), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // One cycle of stimulus; outputs are sampled 1 ns after the capturing edge.
  task automatic step(input bit w, input logic [8:0] wd, input bit r, input bit rt);
    @(negedge clk);
    wr_stb = w; wr_data = wd; rd_stb = r; rewind = rt;
    @(posedge clk);
    #1;
    wr_stb = 1'b0; rd_stb = 1'b0; rewind = 1'b0;
  endtask

  task automatic flags(input string req, input int occ);
    chk_eq({req, " empty_n"}, int'(empty_n), int'(occ != 0));
    chk_eq({req, " full_n"},  int'(full_n),  int'(occ != DEPTH));
    chk_eq({req, " half_n"},  int'(half_n),  int'(occ <= DEPTH / 2));
  endtask

  task automatic read_expect(input string req, input logic [8:0] exp);
    step(1'b0, 9'h0, 1'b1, 1'b0);
    chk_eq({req, " rd_valid"}, int'(rd_valid), 1);
    chk_eq({req, " rd_data"},  int'(rd_data),  int'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_stb = 1'b0; rd_stb = 1'b0; rewind = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R2: state while reset is held
    chk_eq("R2 held empty_n", int'(empty_n), 0);
    chk_eq("R2 held rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    flags("R2", 0);
    chk_eq("R2 rd_valid", int'(rd_valid), 0);
  endtask

  task automatic t_fill_drain();
    logic [8:0] w [DEPTH];
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      w[i] = 9'h100 + 9'(i * 37);
      step(1'b1, w[i], 1'b0, 1'b0);
      flags("R7 R3 R6 fill", i + 1);
      chk_eq("R11 no read no valid", int'(rd_valid), 0);
    end
    // R3: write while full is ignored
    step(1'b1, 9'h0AA, 1'b0, 1'b0);
    flags("R3 write on full", DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      read_expect("R1 R11 drain", w[i]);
      flags("R4 R5 R7 drain", DEPTH - 1 - i);
    end
    // R5: read while empty is ignored
    step(1'b0, 9'h0, 1'b1, 1'b0);
    chk_eq("R5 read on empty rd_valid", int'(rd_valid), 0);
    flags("R5 read on empty", 0);
    // R5: read pointer did not move -> new write comes straight back
    step(1'b1, 9'h1C3, 1'b0, 1'b0);
    read_expect("R5 pointer held", 9'h1C3);
  endtask

  task automatic t_simul();
    do_reset();
    step(1'b1, 9'h011, 1'b0, 1'b0);
    step(1'b1, 9'h122, 1'b0, 1'b0);
    step(1'b1, 9'h033, 1'b0, 1'b0);
    step(1'b1, 9'h144, 1'b1, 1'b0);
    chk_eq("R10 data", int'(rd_data), 'h011);
    flags("R10 level kept", 3);
    step(1'b1, 9'h055, 1'b1, 1'b0);
    chk_eq("R10 data 2", int'(rd_data), 'h122);
    flags("R10 level kept 2", 3);
    read_expect("R10 tail", 9'h033);
    read_expect("R10 tail", 9'h144);
    read_expect("R10 tail", 9'h055);
    flags("R5 emptied", 0);
    // R6: write accepted on empty while read strobe refused
    step(1'b1, 9'h1EE, 1'b1, 1'b0);
    chk_eq("R5 blocked read rd_valid", int'(rd_valid), 0);
    chk_eq("R6 empty_n released", int'(empty_n), 1);
    read_expect("R6 read after write", 9'h1EE);
  endtask

  task automatic t_rewind();
    logic [8:0] w [DEPTH];
    do_reset();
    for (int i = 0; i < 6; i++) begin
      w[i] = 9'h0F0 ^ 9'(i * 53);
      step(1'b1, w[i], 1'b0, 1'b0);
    end
    for (int i = 0; i < 4; i++) read_expect("R1 pre-rewind", w[i]);
    // R9: rewind with read strobe is ignored, the read proceeds
    step(1'b0, 9'h0, 1'b1, 1'b1);
    chk_eq("R9 read during rewind", int'(rd_data), int'(w[4]));
    flags("R9 level", 1);
    // R8: rewind alone
    step(1'b0, 9'h0, 1'b0, 1'b1);
    flags("R8 after rewind", 6);
    read_expect("R8 replay", w[0]);
    read_expect("R8 replay", w[1]);
    // R9: rewind with write strobe is ignored, the write proceeds
    w[6] = 9'h1A5;
    step(1'b1, w[6], 1'b0, 1'b1);
    flags("R9 write during rewind", 5);
    read_expect("R9 no rewind", w[2]);
    w[7] = 9'h05A;
    step(1'b1, w[7], 1'b0, 1'b0);
    // R8: rewind with DEPTH words written since reset -> full
    step(1'b0, 9'h0, 1'b0, 1'b1);
    flags("R8 rewind to full", DEPTH);
    for (int i = 0; i < DEPTH; i++) read_expect("R8 full replay", w[i]);
    flags("R8 replay done", 0);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0;
    rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; rewind = 1'b0; wr_data = '0;
    t_reset();
    t_fill_drain();
    t_simul();
    t_rewind();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule